// File: doc/BRIEF.md
# Walking and Galloping Pattern Memory Tester

This block drives a quadratic pattern test on an external single-bit synchronous RAM of N = 2^ADDR_W cells, addressed linearly. A pulse on `start` while the block is idle begins a run. The `mode` value seen at that moment selects one of two tests that share the same sequencer and compare path: a walking test, or a galloping test. `busy` stays high for the whole run. `done` rises after the run and holds until the next start.

A run has two phases, one per background value: 0 first, then 1. Each phase begins by writing the background into every cell in ascending address order. Then each cell in turn becomes the base cell. The base cell receives the inverse of the background. Every other cell is then read and compared against the background. The base cell itself is read back and expected to hold the inverse. After that the base cell is restored to the background and the next base cell follows. In galloping mode the base cell is read again after each read of another cell. In walking mode it is read once, after the last of the other cells.

The RAM returns read data one cycle after the address. The block compares that data in the following cycle. The first mismatch latches the address read, the base cell in use and the expected bit. A sticky fail flag stays set until the next run begins. The run always finishes.

Top module: `mt_tester`

## Requirements
- R1: After reset, `busy`, `done`, `mem_we` and `fail_any` are all 0.
- R2: `start` with the block idle or done makes `busy` 1 from the next cycle. `start` while `busy` is 1 has no effect on the operation sequence or the run length.
- R3: Each background phase opens with N consecutive write cycles to addresses 0, 1, ..., N-1, each writing the background bit (0 in the first phase, 1 in the second).
- R4: For each base cell b, taken in ascending order, there is one write of the inverted background to b. Then the cells other than b are read in ascending order, each expected to equal the background.
- R5: With `mode`=1 (galloping), each read of another cell is followed directly by a read of b, expected to hold the inverted background.
- R6: With `mode`=0 (walking), b is read exactly once, directly after the last other-cell read, and that read is followed directly by the restore write to b.
- R7: After its reads, b is rewritten with the background before the next base cell. After base N-1 of background 0, the whole phase repeats with background 1.
- R8: `busy` stays high for exactly 4N²+2N cycles in galloping mode and 2N²+6N cycles in walking mode. After that, `done`=1 and `busy`=0 until the next accepted start.
- R9: Read data is compared one cycle after the address is issued. The first mismatch sets `fail_any` and latches `fail_addr`, `fail_base` and `fail_exp`. Later mismatches leave these values unchanged. An accepted start clears `fail_any`.
- R10: A stuck-at cell, or an inversion coupling between any two distinct cells, sets `fail_any` in either mode.
- R11: `cur_base` equals the base cell being worked on during its write, its reads and its restore.
- R12: `mode` is sampled only when a start is accepted. Changes while `busy` is 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run when idle or done |
| mode | input | 1 | 1 = galloping, 0 = walking |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, held until next start |
| mem_addr | output | ADDR_W | RAM address |
| mem_we | output | 1 | RAM write enable (otherwise a read when busy) |
| mem_wdata | output | 1 | RAM write bit |
| mem_rdata | input | 1 | RAM read bit, valid one cycle after address |
| cur_base | output | ADDR_W | Current base cell |
| fail_any | output | 1 | Sticky mismatch flag |
| fail_addr | output | ADDR_W | Address of first mismatching read |
| fail_base | output | ADDR_W | Base cell at first mismatch |
| fail_exp | output | 1 | Expected bit at first mismatch |

## Verification
The bench drives the block with a fault-free RAM in both modes. It compares every cycle's operation against a nested-loop model of the pattern, which separates sequencing, ordering and run-length errors from compare errors. Stuck-at cells at the lowest and highest address show whether both other-cell and base-cell reads are compared against the right bit. Inversion couplings with the aggressor above and below the victim show whether a victim is re-read after its aggressor's base write. In every run, `start` is pulsed and `mode` is toggled at random mid-run, so the block must ignore them. Randomly placed faults and modes under a fixed seed add further cases. Each run also checks the first-fail record against the first mismatch the bench itself observed.

// File: rtl/mt_pkg.sv
package mt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_WBASE,
    ST_SWEEP,
    ST_RBASE,
    ST_RESTORE,
    ST_DONE
  } mt_state_e;

  // Map a compact index 0..N-2 onto the addresses other than base.
  function automatic int unsigned skip_base(int unsigned idx, int unsigned base);
    return (idx >= base) ? idx + 1 : idx;
  endfunction

  // Busy cycles of one complete run over n cells.
  function automatic int unsigned run_cycles(int unsigned n, logic gallop);
    return gallop ? (4 * n * n + 2 * n) : (2 * n * n + 6 * n);
  endfunction

endpackage

// File: rtl/mt_seq.sv
module mt_seq
  import mt_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mode,
  output logic              busy,
  output logic              done,
  output logic              start_acc,
  output logic              mode_q,
  output logic              op_we,
  output logic              op_rd,
  output logic              op_wdata,
  output logic              op_exp,
  output logic [ADDR_W-1:0] op_addr,
  output logic [ADDR_W-1:0] base
);

  localparam int N = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] LAST     = ADDR_W'(N - 1);
  localparam logic [ADDR_W-1:0] LAST_OTH = ADDR_W'(N - 2);

  mt_state_e         st_q, st_d;
  logic              bg_q, bg_d;
  logic              gal_q, gal_d;
  logic              ph_q, ph_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [ADDR_W-1:0] idx_q, idx_d;
  logic [ADDR_W-1:0] other_addr;

  assign start_acc  = start && ((st_q == ST_IDLE) || (st_q == ST_DONE));
  assign busy       = (st_q != ST_IDLE) && (st_q != ST_DONE);
  assign done       = (st_q == ST_DONE);
  assign mode_q     = gal_q;
  assign base       = base_q;
  assign other_addr = ADDR_W'(skip_base(32'(idx_q), 32'(base_q)));

  always_comb begin
    st_d   = st_q;
    bg_d   = bg_q;
    gal_d  = gal_q;
    ph_d   = ph_q;
    base_d = base_q;
    idx_d  = idx_q;
    unique case (st_q)
      ST_IDLE, ST_DONE: begin
        if (start_acc) begin
          st_d   = ST_FILL;
          bg_d   = 1'b0;
          gal_d  = mode;
          ph_d   = 1'b0;
          base_d = '0;
          idx_d  = '0;
        end
      end
      ST_FILL: begin
        if (idx_q == LAST) begin
          st_d  = ST_WBASE;
          idx_d = '0;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      ST_WBASE: begin
        st_d  = ST_SWEEP;
        idx_d = '0;
        ph_d  = 1'b0;
      end
      ST_SWEEP: begin
        if (gal_q && !ph_q) begin
          ph_d = 1'b1;
        end else begin
          ph_d = 1'b0;
          if (idx_q == LAST_OTH) begin
            st_d = gal_q ? ST_RESTORE : ST_RBASE;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      ST_RBASE: st_d = ST_RESTORE;
      ST_RESTORE: begin
        if (base_q == LAST) begin
          base_d = '0;
          idx_d  = '0;
          if (!bg_q) begin
            bg_d = 1'b1;
            st_d = ST_FILL;
          end else begin
            st_d = ST_DONE;
          end
        end else begin
          base_d = base_q + 1'b1;
          st_d   = ST_WBASE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    op_we    = 1'b0;
    op_rd    = 1'b0;
    op_addr  = '0;
    op_wdata = bg_q;
    op_exp   = bg_q;
    unique case (st_q)
      ST_FILL: begin
        op_we   = 1'b1;
        op_addr = idx_q;
      end
      ST_WBASE: begin
        op_we    = 1'b1;
        op_addr  = base_q;
        op_wdata = ~bg_q;
      end
      ST_SWEEP: begin
        op_rd = 1'b1;
        if (gal_q && ph_q) begin
          op_addr = base_q;
          op_exp  = ~bg_q;
        end else begin
          op_addr = other_addr;
        end
      end
      ST_RBASE: begin
        op_rd   = 1'b1;
        op_addr = base_q;
        op_exp  = ~bg_q;
      end
      ST_RESTORE: begin
        op_we   = 1'b1;
        op_addr = base_q;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      bg_q   <= 1'b0;
      gal_q  <= 1'b0;
      ph_q   <= 1'b0;
      base_q <= '0;
      idx_q  <= '0;
    end else begin
      st_q   <= st_d;
      bg_q   <= bg_d;
      gal_q  <= gal_d;
      ph_q   <= ph_d;
      base_q <= base_d;
      idx_q  <= idx_d;
    end
  end

endmodule

// File: rtl/mt_cmp.sv
module mt_cmp #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              chk_en,
  input  logic              chk_exp,
  input  logic [ADDR_W-1:0] chk_addr,
  input  logic [ADDR_W-1:0] chk_base,
  input  logic              rdata,
  output logic              miscompare,
  output logic              fail_any,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [ADDR_W-1:0] fail_base,
  output logic              fail_exp
);

  logic              pend_v;
  logic              pend_exp;
  logic [ADDR_W-1:0] pend_addr;
  logic [ADDR_W-1:0] pend_base;

  assign miscompare = pend_v && (rdata != pend_exp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v    <= 1'b0;
      pend_exp  <= 1'b0;
      pend_addr <= '0;
      pend_base <= '0;
      fail_any  <= 1'b0;
      fail_addr <= '0;
      fail_base <= '0;
      fail_exp  <= 1'b0;
    end else begin
      pend_v    <= chk_en;
      pend_exp  <= chk_exp;
      pend_addr <= chk_addr;
      pend_base <= chk_base;
      if (clr) begin
        fail_any  <= 1'b0;
        fail_addr <= '0;
        fail_base <= '0;
        fail_exp  <= 1'b0;
      end else if (miscompare && !fail_any) begin
        fail_any  <= 1'b1;
        fail_addr <= pend_addr;
        fail_base <= pend_base;
        fail_exp  <= pend_exp;
      end
    end
  end

endmodule

// File: rtl/mt_tester.sv
module mt_tester #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mode,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic              mem_wdata,
  input  logic              mem_rdata,
  output logic [ADDR_W-1:0] cur_base,
  output logic              fail_any,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [ADDR_W-1:0] fail_base,
  output logic              fail_exp
);

  logic start_acc;
  logic mode_q;
  logic rd_issue;
  logic rd_exp;
  logic miscompare;

  mt_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mode      (mode),
    .busy      (busy),
    .done      (done),
    .start_acc (start_acc),
    .mode_q    (mode_q),
    .op_we     (mem_we),
    .op_rd     (rd_issue),
    .op_wdata  (mem_wdata),
    .op_exp    (rd_exp),
    .op_addr   (mem_addr),
    .base      (cur_base)
  );

  mt_cmp #(.ADDR_W(ADDR_W)) u_cmp (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (start_acc),
    .chk_en     (rd_issue),
    .chk_exp    (rd_exp),
    .chk_addr   (mem_addr),
    .chk_base   (cur_base),
    .rdata      (mem_rdata),
    .miscompare (miscompare),
    .fail_any   (fail_any),
    .fail_addr  (fail_addr),
    .fail_base  (fail_base),
    .fail_exp   (fail_exp)
  );

endmodule

// File: rtl/mt_tester_chk.sv
module mt_tester_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_acc,
  input logic              busy,
  input logic              done,
  input logic              mode_q,
  input logic              rd_issue,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] cur_base,
  input logic              miscompare,
  input logic              fail_any
);

  localparam int N = 1 << ADDR_W;

  int unsigned busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         busy_cnt <= 0;
    else if (start_acc) busy_cnt <= 0;
    else if (busy)      busy_cnt <= busy_cnt + 1;
  end

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> busy);

  // R5
  gallop_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_issue && mode_q && (mem_addr != cur_base)) |=> (rd_issue && (mem_addr == cur_base)));

  // R6
  walk_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_issue && !mode_q && (mem_addr == cur_base)) |=> (mem_we && (mem_addr == $past(mem_addr))));

  // R8
  run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_cnt == mt_pkg::run_cycles(N, mode_q)));

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R8
  busy_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (mem_we || rd_issue));

  // R9
  fail_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miscompare && !start_acc) |=> fail_any);

  // R9
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_any && !start_acc) |=> fail_any);

  // R12
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mode_q));

endmodule

bind mt_tester mt_tester_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_acc  (start_acc),
  .busy       (busy),
  .done       (done),
  .mode_q     (mode_q),
  .rd_issue   (rd_issue),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .cur_base   (cur_base),
  .miscompare (miscompare),
  .fail_any   (fail_any)
);

// File: tb/mt_tester_tb.sv
module mt_tester_tb;

  localparam int AW = 4;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic          mode;
  logic          busy, done;
  logic [AW-1:0] mem_addr;
  logic          mem_we, mem_wdata;
  logic          mem_rdata;
  logic [AW-1:0] cur_base;
  logic          fail_any;
  logic [AW-1:0] fail_addr, fail_base;
  logic          fail_exp;

  always #5 clk = ~clk;

  mt_tester #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .busy(busy), .done(done),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .cur_base(cur_base), .fail_any(fail_any), .fail_addr(fail_addr),
    .fail_base(fail_base), .fail_exp(fail_exp)
  );

  // RAM model with fault injection
  logic ram [N];
  logic sa_en = 1'b0, sa_val = 1'b0;
  int   sa_adr = 0;
  logic cf_en = 1'b0;
  int   cf_ag = 0, cf_vi = 0;

  initial begin
    for (int i = 0; i < N; i++) ram[i] = 1'b0;
    mem_rdata = 1'b0;
  end

  always @(posedge clk) begin
    if (mem_we) begin
      if (cf_en && int'(mem_addr) == cf_ag && ram[mem_addr] != mem_wdata)
        ram[cf_vi] <= ~ram[cf_vi];
      ram[mem_addr] <= mem_wdata;
    end else begin
      mem_rdata <= (sa_en && int'(mem_addr) == sa_adr) ? sa_val : ram[mem_addr];
    end
  end

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // per-run tracking
  int op_idx, poke_at;
  bit pend, p_exp;
  int p_addr, p_base;
  bit found, f_exp;
  int f_addr, f_base;

  function automatic int expect_cycles(bit gal);
    return gal ? (4 * N * N + 2 * N) : (2 * N * N + 6 * N);
  endfunction

  // One expected operation; called at the negedge where it is visible.
  task automatic do_op(bit we, int addr, bit val, int base, string req);
    bit ok;
    if (pend && !found && mem_rdata !== p_exp) begin
      found = 1; f_addr = p_addr; f_base = p_base; f_exp = p_exp;
    end
    ok = busy && (mem_we === we) && (int'(mem_addr) == addr) && (!we || mem_wdata === val);
    chk(ok, req, "operation address", int'(mem_addr) + (mem_we ? 1000 : 0),
        addr + (we ? 1000 : 0));
    if (base >= 0) chk(int'(cur_base) == base, "R11", "cur_base", int'(cur_base), base);
    pend = !we; p_addr = addr; p_exp = val; p_base = base;
    start = (op_idx == poke_at);
    mode  = 1'($urandom);
    op_idx++;
    @(negedge clk);
  endtask

  task automatic run(bit gal);
    int total = 0;
    mode  = gal;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(fail_any == 1'b0, "R9", "fail cleared at start", int'(fail_any), 0);
    op_idx = 0; pend = 0; found = 0;
    poke_at = 1 + int'($urandom_range(expect_cycles(gal) - 3));
    for (int bg = 0; bg < 2; bg++) begin
      for (int a = 0; a < N; a++) do_op(1'b1, a, 1'(bg), -1, "R3");
      for (int b = 0; b < N; b++) begin
        do_op(1'b1, b, ~1'(bg), b, "R4");
        for (int o = 0; o < N; o++) begin
          if (o != b) begin
            do_op(1'b0, o, 1'(bg), b, "R4");
            if (gal) do_op(1'b0, b, ~1'(bg), b, "R5");
          end
        end
        if (!gal) do_op(1'b0, b, ~1'(bg), b, "R6");
        do_op(1'b1, b, 1'(bg), b, "R7");
      end
    end
    start = 1'b0;
    total = op_idx;
    chk(total == expect_cycles(gal), "R8", "op count", total, expect_cycles(gal));
    chk(!busy && done, "R8", "busy/done after run", {30'd0, busy, done}, 1);
    chk(fail_any == found, "R9", "fail_any", int'(fail_any), int'(found));
    if (found) begin
      chk(int'(fail_addr) == f_addr, "R9", "fail_addr", int'(fail_addr), f_addr);
      chk(int'(fail_base) == f_base, "R9", "fail_base", int'(fail_base), f_base);
      chk(fail_exp == f_exp, "R9", "fail_exp", int'(fail_exp), int'(f_exp));
    end
    if (sa_en || cf_en) begin
      chk(found, "R10", "fault seen by model", int'(found), 1);
      chk(fail_any, "R10", "fault flagged", int'(fail_any), 1);
    end
    repeat (3) @(negedge clk);
    chk(done && !busy, "R8", "done held", int'(done), 1);
  endtask

  task automatic set_faults(int kind, int a0, int a1, bit v);
    sa_en = (kind == 1); sa_adr = a0; sa_val = v;
    cf_en = (kind == 2); cf_ag = a0; cf_vi = a1;
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; start = 1'b0; mode = 1'b0;
    repeat (3) @(negedge clk);
    // R1
    chk(!busy && !done && !mem_we && !fail_any, "R1", "reset outputs",
        {28'd0, busy, done, mem_we, fail_any}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: start while idle begins run (checked through run sequence); R12 mode toggling inside do_op
    set_faults(0, 0, 0, 0); run(1'b1);
    set_faults(0, 0, 0, 0); run(1'b0);
    set_faults(1, 0, 0, 1'b1);     run(1'b1);
    set_faults(1, N - 1, 0, 1'b0); run(1'b0);
    set_faults(2, N - 1, 0, 1'b0); run(1'b1);
    set_faults(2, 0, N - 1, 1'b0); run(1'b0);
    for (int r = 0; r < 6; r++) begin
      int kind = int'($urandom_range(2));
      int a0 = int'($urandom_range(N - 1));
      int a1 = (a0 + 1 + int'($urandom_range(N - 2))) % N;
      set_faults(kind, a0, a1, 1'($urandom));
      run(1'($urandom));
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule